// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block carries received network frames from a byte stream into host memory. The host builds a ring of four-word descriptors in memory and hands each one to the engine by setting its ownership flag. The engine reads a descriptor and checks that it owns it. It then stores frame bytes into that descriptor's buffer and writes a closing status word that hands the descriptor back to the host. Next it moves to the following descriptor, which it finds by a chain pointer, by returning to the base address at the end of the ring, or by stepping 16 bytes forward.

When the engine reads a descriptor it does not own, it suspends. While suspended it discards incoming frames whole and waits for a poll-demand write before it reads that descriptor again. A small register port sets the base address, starts and stops the engine, and issues poll demands. A 3-bit output reports what the engine is doing.

Top module: `rxring_dma`

## Requirements
- R1: After reset, `proc_state` reads 0 (stopped) and `mem_req` is low.
- R2: Register writes: address 0 sets the base address, address 1 bit 0 sets run, and address 2 is a poll demand. When run is set while stopped, the engine reads descriptor words at base+0, +4, +8 and +12, in that order. A memory request holds its address and direction until `mem_ack`.
- R3: A descriptor whose word0 bit 31 is 0 is not owned. After reading such a word0, the engine reads no more words of that descriptor, makes no memory writes and enters state 5 (suspended).
- R4: Word1 bits 11:0 give the buffer size, which must be nonzero. Word2 gives the word-aligned buffer address. Byte k of a segment is written to address buf+(k with bits 1:0 cleared), with byte enable 1<<(k mod 4) and the byte in lane k mod 4.
- R5: A frame that fits in one buffer closes its descriptor with word0 = length in bits 29:16, error summary in bit 15, first-segment in bit 9, last-segment in bit 8, and every other bit 0, including bit 31.
- R6: A frame longer than the buffer goes on into the next descriptors. The first segment closes with only bit 9 set. The final segment closes with bit 8, the whole frame length and the error summary. Any middle segment closes as all zeros.
- R7: The error summary (bit 15) is set when `in_err` was high on any byte of the frame, in any segment.
- R8: After a close, the next descriptor is the base address if word1 bit 15 is set (this wins over bit 14). Otherwise it is word3 if word1 bit 14 is set, and otherwise the current descriptor address +16.
- R9: A poll demand while suspended makes the engine read the same descriptor again. If that descriptor is still not owned, the engine suspends again. If it is owned, the engine goes on to wait for a frame. A poll demand made while a frame is being discarded takes effect after that frame's last byte.
- R10: While suspended, the engine accepts (`in_ready` high) and discards every byte up to and including the one marked last. It makes no memory access and stays suspended.
- R11: Clearing run while waiting for a frame or while suspended moves the engine to state 0. Setting run again starts reading at the current base address.
- R12: `proc_state` encodes 1 for fetching a descriptor, 2 for waiting for a frame, 3 for writing frame data (including between bytes of a frame), 4 for closing and 5 for suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 control, 2 poll demand |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_err | input | 1 | Byte carries a receive error |
| in_ready | output | 1 | Engine accepts the byte this cycle |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed |
| proc_state | output | 3 | Process state code |

## Verification
Two events can land in the same cycle. One is a poll demand. The other is the discarding of a frame that started while the engine was suspended. The bench arms the descriptors, sends the first byte of a frame while the engine is suspended, and issues the poll demand before the frame's last byte. It then checks that no descriptor read happens until that last byte is taken, and that the read happens right after. A second pair is a buffer filling up at the same moment a frame continues. The bench sends a frame longer than a four-byte buffer, whose descriptor also carries both the end-of-ring and chain bits. It then checks both closing words, the byte placement in both buffers and the order of descriptor reads.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int WORD_W    = 32;
  localparam int BYTE_W    = 8;
  localparam int LANES     = WORD_W / BYTE_W;
  localparam int SIZE_W    = 12;
  localparam int LEN_W     = 14;
  localparam int DESC_WORDS = 4;
  localparam int WIDX_W    = $clog2(DESC_WORDS);

  localparam int OWN_BIT   = 31;
  localparam int ES_BIT    = 15;
  localparam int FS_BIT    = 9;
  localparam int LS_BIT    = 8;
  localparam int LEN_LSB   = 16;
  localparam int EOR_BIT   = 15;
  localparam int CHAIN_BIT = 14;

  localparam logic [1:0] REG_BASE = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_POLL = 2'd2;

  typedef enum logic [2:0] {
    PS_STOPPED = 3'd0,
    PS_FETCH   = 3'd1,
    PS_WAIT    = 3'd2,
    PS_WRITE   = 3'd3,
    PS_CLOSE   = 3'd4,
    PS_SUSPEND = 3'd5
  } pstate_e;

  typedef enum logic [2:0] {
    E_STOP, E_FETCH, E_RECV, E_WR, E_CLOSE, E_SUSP
  } est_e;

  function automatic logic [WORD_W-1:0] close_word(input logic first, input logic last,
                                                   input logic err, input logic [LEN_W-1:0] len);
    logic [WORD_W-1:0] w;
    w = '0;
    w[FS_BIT] = first;
    if (last) begin
      w[LS_BIT] = 1'b1;
      w[ES_BIT] = err;
      w[LEN_LSB +: LEN_W] = len;
    end
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] next_desc(input logic [WORD_W-1:0] cur,
                                                  input logic eor, input logic chain,
                                                  input logic [WORD_W-1:0] link,
                                                  input logic [WORD_W-1:0] base);
    if (eor)        return base;
    else if (chain) return link;
    else            return cur + WORD_W'(DESC_WORDS * LANES);
  endfunction

  function automatic logic [LANES-1:0] lane_enable(input logic [1:0] off);
    return LANES'(1) << off;
  endfunction

  function automatic logic [WORD_W-1:0] buf_word_addr(input logic [WORD_W-1:0] bufa,
                                                      input logic [SIZE_W:0] off);
    return bufa + {{(WORD_W-SIZE_W-1){1'b0}}, off[SIZE_W:2], 2'b00};
  endfunction
endpackage

// File: rtl/rxring_regs.sv
module rxring_regs
  import rxring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] base_addr,
  output logic              run,
  output logic              poll
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      run       <= 1'b0;
      poll      <= 1'b0;
    end else begin
      poll <= reg_we && (reg_addr == REG_POLL);
      if (reg_we && reg_addr == REG_BASE) base_addr <= reg_wdata;
      if (reg_we && reg_addr == REG_CTRL) run <= reg_wdata[0];
    end
  end
endmodule

// File: rtl/rxring_seg.sv
module rxring_seg
  import rxring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_clr,
  input  logic             frame_clr,
  input  logic             step,
  input  logic             step_err,
  output logic [SIZE_W:0]  seg_off,
  output logic [LEN_W-1:0] frame_len,
  output logic             frame_err
);
  localparam logic [SIZE_W:0]  OFF_ONE = {{SIZE_W{1'b0}}, 1'b1};
  localparam logic [LEN_W-1:0] LEN_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_off   <= '0;
      frame_len <= '0;
      frame_err <= 1'b0;
    end else begin
      if (seg_clr)   seg_off <= '0;
      else if (step) seg_off <= seg_off + OFF_ONE;
      if (frame_clr) begin
        frame_len <= '0;
        frame_err <= 1'b0;
      end else if (step) begin
        frame_len <= frame_len + LEN_ONE;
        frame_err <= frame_err | step_err;
      end
    end
  end
endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
  import rxring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] base_addr,
  input  logic              run,
  input  logic              poll,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_err,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [2:0]        proc_state,
  input  logic [SIZE_W:0]   seg_off,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              frame_err,
  output logic              seg_clr,
  output logic              frame_clr,
  output logic              step,
  output logic              step_err
);
  localparam logic [SIZE_W:0] OFF_ONE = {{SIZE_W{1'b0}}, 1'b1};
  localparam logic [WIDX_W-1:0] WIDX_LAST = WIDX_W'(DESC_WORDS - 1);

  est_e              st;
  logic [WIDX_W-1:0] widx;
  logic [WORD_W-1:0] desc_addr, buf_addr, link;
  logic [SIZE_W-1:0] seg_size;
  logic              ctl_eor, ctl_chain;
  logic [BYTE_W-1:0] byte_q;
  logic              last_q, err_q;
  logic              in_frame, first_seg, drop, poll_pend;

  // named internal events
  logic fetch_ack, w0_ack, desc_done, wr_ack, close_ack, seg_full;
  logic recv_stop, leave_susp, leave_stop, take;

  assign fetch_ack  = (st == E_FETCH) && mem_ack;
  assign w0_ack     = fetch_ack && (widx == '0);
  assign desc_done  = fetch_ack && (widx == WIDX_LAST);
  assign wr_ack     = (st == E_WR) && mem_ack;
  assign close_ack  = (st == E_CLOSE) && mem_ack;
  assign seg_full   = (seg_off + OFF_ONE) == {1'b0, seg_size};
  assign recv_stop  = !run && !in_frame;
  assign leave_susp = run && poll_pend && !drop;
  assign leave_stop = run && !drop;

  always_comb begin
    case (st)
      E_RECV:  in_ready = !recv_stop;
      E_SUSP:  in_ready = !leave_susp;
      E_STOP:  in_ready = !leave_stop;
      default: in_ready = 1'b0;
    endcase
  end
  assign take = in_valid && in_ready;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_be    = '0;
    mem_wdata = '0;
    case (st)
      E_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + {{(WORD_W-WIDX_W-2){1'b0}}, widx, 2'b00};
      end
      E_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_word_addr(buf_addr, seg_off);
        mem_be    = lane_enable(seg_off[1:0]);
        mem_wdata = {LANES{byte_q}};
      end
      E_CLOSE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr;
        mem_be    = '1;
        mem_wdata = close_word(first_seg, last_q, frame_err, frame_len);
      end
      default: ;
    endcase
  end

  always_comb begin
    case (st)
      E_STOP:  proc_state = PS_STOPPED;
      E_FETCH: proc_state = PS_FETCH;
      E_RECV:  proc_state = in_frame ? PS_WRITE : PS_WAIT;
      E_WR:    proc_state = PS_WRITE;
      E_CLOSE: proc_state = PS_CLOSE;
      default: proc_state = PS_SUSPEND;
    endcase
  end

  assign step      = wr_ack;
  assign step_err  = err_q;
  assign seg_clr   = desc_done;
  assign frame_clr = (close_ack && last_q) || (w0_ack && !mem_rdata[OWN_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= E_STOP;
      widx      <= '0;
      desc_addr <= '0;
      buf_addr  <= '0;
      link      <= '0;
      seg_size  <= '0;
      ctl_eor   <= 1'b0;
      ctl_chain <= 1'b0;
      byte_q    <= '0;
      last_q    <= 1'b0;
      err_q     <= 1'b0;
      in_frame  <= 1'b0;
      first_seg <= 1'b0;
      drop      <= 1'b0;
      poll_pend <= 1'b0;
    end else begin
      if (st == E_SUSP && run && !leave_susp) poll_pend <= poll_pend | poll;
      else                                    poll_pend <= 1'b0;
      case (st)
        E_STOP: begin
          if (leave_stop) begin
            desc_addr <= base_addr;
            widx      <= '0;
            st        <= E_FETCH;
          end else if (take) begin
            drop <= !in_last;
          end
        end
        E_FETCH: begin
          if (mem_ack) begin
            case (widx)
              2'd0: begin
                if (!mem_rdata[OWN_BIT]) begin
                  st       <= E_SUSP;
                  drop     <= in_frame;
                  in_frame <= 1'b0;
                end else begin
                  widx <= 2'd1;
                end
              end
              2'd1: begin
                seg_size  <= mem_rdata[SIZE_W-1:0];
                ctl_eor   <= mem_rdata[EOR_BIT];
                ctl_chain <= mem_rdata[CHAIN_BIT];
                widx      <= 2'd2;
              end
              2'd2: begin
                buf_addr <= mem_rdata;
                widx     <= 2'd3;
              end
              default: begin
                link      <= mem_rdata;
                first_seg <= 1'b0;
                widx      <= '0;
                st        <= E_RECV;
              end
            endcase
          end
        end
        E_RECV: begin
          if (recv_stop) begin
            st <= E_STOP;
          end else if (take) begin
            byte_q   <= in_data;
            last_q   <= in_last;
            err_q    <= in_err;
            in_frame <= 1'b1;
            if (!in_frame) first_seg <= 1'b1;
            st <= E_WR;
          end
        end
        E_WR: begin
          if (mem_ack) st <= (last_q || seg_full) ? E_CLOSE : E_RECV;
        end
        E_CLOSE: begin
          if (mem_ack) begin
            desc_addr <= next_desc(desc_addr, ctl_eor, ctl_chain, link, base_addr);
            if (last_q) in_frame <= 1'b0;
            widx <= '0;
            st   <= E_FETCH;
          end
        end
        default: begin
          if (!run)            st <= E_STOP;
          else if (leave_susp) begin
            widx <= '0;
            st   <= E_FETCH;
          end
          if (take) drop <= !in_last;
        end
      endcase
    end
  end

  // R2: a pending memory request keeps its address and direction
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R3: suspension is entered only after an unowned word0 was read
  assert_susp_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == E_SUSP) |-> $past(w0_ack && !mem_rdata[OWN_BIT]));

  // R4: data writes stay inside the allocated buffer
  assert_wr_in_buf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_WR && mem_req) |-> (seg_off < {1'b0, seg_size}));

  // R6: the write of a last byte is followed by a close
  assert_last_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && last_q) |=> (st == E_CLOSE));

  // R10: accepting stream bytes never overlaps a memory access
  assert_ready_no_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_req);
endmodule

// File: rtl/rxring_dma.sv
module rxring_dma
  import rxring_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        in_err,
  output logic        in_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic [2:0]  proc_state
);
  logic [WORD_W-1:0] base_addr;
  logic              run, poll;
  logic [SIZE_W:0]   seg_off;
  logic [LEN_W-1:0]  frame_len;
  logic              frame_err, seg_clr, frame_clr, step, step_err;

  rxring_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .base_addr(base_addr), .run(run), .poll(poll)
  );

  rxring_seg u_seg (
    .clk(clk), .rst_n(rst_n), .seg_clr(seg_clr), .frame_clr(frame_clr),
    .step(step), .step_err(step_err), .seg_off(seg_off),
    .frame_len(frame_len), .frame_err(frame_err)
  );

  rxring_engine u_eng (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .run(run), .poll(poll),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .proc_state(proc_state), .seg_off(seg_off), .frame_len(frame_len),
    .frame_err(frame_err), .seg_clr(seg_clr), .frame_clr(frame_clr),
    .step(step), .step_err(step_err)
  );
endmodule

// File: tb/test_rxring_dma.sv
module test_rxring_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_err = 1'b0;
  logic        in_ready, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic [2:0]  proc_state;

  logic [31:0] mem [0:1023];
  logic [31:0] rd_log [0:255];
  int          rd_n = 0;
  int          wr_n = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [7:0]  seen = '0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  rxring_dma i_rxring_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .proc_state(proc_state)
  );

  // memory model: one idle cycle, then a one-cycle acknowledge
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst_n && mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] = mem_wdata[8*b +: 8];
        wr_n = wr_n + 1;
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
        rd_log[rd_n[7:0]] = mem_addr;
        rd_n = rd_n + 1;
      end
    end
  end

  always @(negedge clk) if (rst_n) seen[proc_state] <= 1'b1;

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic l, input logic e);
    int k = 0;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = l; in_err = e;
    while (!in_ready && k < 1000) begin
      @(negedge clk);
      k++;
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_state(input logic [2:0] code, input string tag);
    int k = 0;
    @(negedge clk);
    while (proc_state !== code && k < 2000) begin
      @(negedge clk);
      k++;
    end
    check32(tag, {29'd0, proc_state}, {29'd0, code});
  endtask

  task automatic arm(input int a, input logic [31:0] w1, input logic [31:0] b, input logic [31:0] nx);
    mem[(a >> 2) + 1] = w1;
    mem[(a >> 2) + 2] = b;
    mem[(a >> 2) + 3] = nx;
    mem[a >> 2] = 32'h8000_0000;
  endtask

  task automatic t_reset;
    check32("R1 state after reset", {29'd0, proc_state}, 32'd0);
    check32("R1 mem_req after reset", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_single;
    arm(32'h100, (32'd1 << 14) | 32'd64, 32'h400, 32'h200);
    reg_write(2'd0, 32'h100);
    reg_write(2'd1, 32'h1);
    wait_state(3'd2, "R2 waiting after fetch");
    check32("R2 read 0", rd_log[0], 32'h100);
    check32("R2 read 1", rd_log[1], 32'h104);
    check32("R2 read 2", rd_log[2], 32'h108);
    check32("R2 read 3", rd_log[3], 32'h10C);
    send_byte(8'h11, 0, 0); send_byte(8'h22, 0, 0); send_byte(8'h33, 0, 0);
    send_byte(8'h44, 0, 0); send_byte(8'h55, 0, 0); send_byte(8'h66, 1, 0);
    wait_state(3'd5, "R3 suspended on unowned descriptor");
    check32("R5 close word single frame", mem[32'h100 >> 2], 32'h0006_0300);
    check32("R4 buffer word 0", mem[32'h400 >> 2], 32'h4433_2211);
    check32("R4 buffer word 1 partial lanes", mem[32'h404 >> 2], 32'h0000_6655);
    check32("R8 chained next read", rd_log[rd_n - 1], 32'h200);
    check32("R3 no further reads", rd_n, 32'd5);
    check32("R3 writes only for frame", wr_n, 32'd7);
  endtask

  task automatic t_drop;
    int r0 = rd_n;
    int w0 = wr_n;
    send_byte(8'hA0, 0, 0); send_byte(8'hA1, 0, 1); send_byte(8'hA2, 1, 0);
    repeat (10) @(negedge clk);
    check32("R10 no writes while suspended", wr_n, w0);
    check32("R10 no reads while suspended", rd_n, r0);
    check32("R10 stays suspended", {29'd0, proc_state}, 32'd5);
  endtask

  task automatic t_poll;
    int r0 = rd_n;
    reg_write(2'd2, 32'h1);
    repeat (20) @(negedge clk);
    check32("R9 poll refetches once", rd_n, r0 + 1);
    check32("R9 refetch same descriptor", rd_log[rd_n - 1], 32'h200);
    check32("R9 still suspended", {29'd0, proc_state}, 32'd5);
    arm(32'h200, (32'd1 << 15) | (32'd1 << 14) | 32'd4, 32'h500, 32'h300);
    arm(32'h100, 32'd64, 32'h600, 32'h0);
    r0 = rd_n;
    send_byte(8'hB0, 0, 0);
    reg_write(2'd2, 32'h1);
    repeat (20) @(negedge clk);
    check32("R9 poll deferred during drop", rd_n, r0);
    check32("R10 suspended during drop", {29'd0, proc_state}, 32'd5);
    send_byte(8'hB1, 1, 0);
    wait_state(3'd2, "R9 resumes after dropped frame");
    check32("R9 resumed reads", rd_n, r0 + 4);
    check32("R9 resumed at same descriptor", rd_log[r0[7:0]], 32'h200);
  endtask

  task automatic t_multi;
    send_byte(8'hA1, 0, 0); send_byte(8'hA2, 0, 0); send_byte(8'hA3, 0, 1);
    send_byte(8'hA4, 0, 0); send_byte(8'hA5, 0, 0); send_byte(8'hA6, 1, 0);
    wait_state(3'd5, "R8 suspends at sequential descriptor");
    check32("R6 first segment close", mem[32'h200 >> 2], 32'h0000_0200);
    check32("R4 first buffer", mem[32'h500 >> 2], 32'hA4A3_A2A1);
    check32("R6 R7 last segment close", mem[32'h100 >> 2], 32'h0006_8100);
    check32("R4 second buffer", mem[32'h600 >> 2], 32'h0000_A6A5);
    check32("R8 end of ring wins", rd_log[rd_n - 5], 32'h100);
    check32("R8 sequential step", rd_log[rd_n - 1], 32'h110);
  endtask

  task automatic t_stop;
    int r0;
    reg_write(2'd1, 32'h0);
    wait_state(3'd0, "R11 stop from suspended");
    reg_write(2'd0, 32'h180);
    arm(32'h180, (32'd1 << 14) | 32'd8, 32'h700, 32'h190);
    r0 = rd_n;
    reg_write(2'd1, 32'h1);
    wait_state(3'd2, "R11 restart waits");
    check32("R11 restart at new base", rd_log[r0[7:0]], 32'h180);
    reg_write(2'd1, 32'h0);
    wait_state(3'd0, "R11 stop from waiting");
    check32("R11 no reads after stop", rd_n, r0 + 4);
  endtask

  task automatic t_states;
    check32("R12 fetch state seen", {31'd0, seen[1]}, 32'd1);
    check32("R12 write state seen", {31'd0, seen[3]}, 32'd1);
    check32("R12 close state seen", {31'd0, seen[4]}, 32'd1);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_drop();
    t_poll();
    t_multi();
    t_stop();
    t_states();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule